// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block converts a 16-bit virtual address into a physical address of up to 22 bits. It looks up a page base register and a page descriptor register in a register file. The register file is split into banks by processor privilege level and by whether the reference is an instruction fetch or a data access. The page base is a relocation constant counted in 64-byte blocks. It is added to the block number taken from the virtual address, and the low six address bits pass through unchanged.

Two control inputs set the translation width. One selects either the full 22-bit result or an 18-bit result that uses only the low 12 bits of the base. A per-level data-space enable decides whether data references get their own bank or share the instruction bank of the same level. When translation is off, the virtual address goes straight through. A synchronous write port loads any base or descriptor register. The descriptor of the selected page is presented on an output so that a neighbouring access checker can use it.

Top module: `vaddr_xlat`

## Requirements
- R1: `va_i[15:13]` picks one of eight pages in the bank, `va_i[12:6]` is the 7-bit block number and `va_i[5:0]` is the byte offset within the block.
- R2: With translation on and `map22_i`=1, `pa_o[21:6]` equals the selected 16-bit base plus the zero-extended block number, taken modulo 2^16.
- R3: With translation on and a valid level, `pa_o[5:0]` equals `va_i[5:0]`.
- R4: With translation on and `map22_i`=0, `pa_o[17:6]` equals the low 12 base bits plus the block number, taken modulo 2^12, and `pa_o[21:18]` is zero.
- R5: The bank is chosen by `mode_i` (00 kernel, 01 supervisor, 11 user) together with `dspace_i` (1 = data reference), which gives six independent banks of eight base/descriptor pairs.
- R6: With `xlat_en_i`=0, `pa_o` is `{6'b0, va_i}` and `desc_o` is zero.
- R7: `dspace_en_i` bit 0 (kernel), bit 1 (supervisor) and bit 2 (user) enable separate data banks. When the bit for the current level is 0, data references use that level's instruction bank.
- R8: On a rising clock edge with `wr_en_i`=1, `wr_data_i` is stored into the base register (`wr_sel_i`=0) or the descriptor register (`wr_sel_i`=1) addressed by `wr_mode_i`, `wr_dspace_i` and `wr_page_i`. No other register changes, and outputs change only through their inputs or such a write.
- R9: `rst_ni` low clears every base and descriptor register asynchronously.
- R10: Level code 10 is reserved. With translation on it drives `pa_o` and `desc_o` to zero, and writes addressed to it are dropped.
- R11: With translation on, `desc_o` shows the descriptor register of the selected page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the write port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| va_i | input | 16 | Virtual address |
| mode_i | input | 2 | Privilege level of the reference |
| dspace_i | input | 1 | 1 = data reference, 0 = instruction |
| xlat_en_i | input | 1 | Translation enable |
| map22_i | input | 1 | 1 = 22-bit mapping, 0 = 18-bit |
| dspace_en_i | input | 3 | Per-level data bank enables |
| wr_en_i | input | 1 | Register write strobe |
| wr_mode_i | input | 2 | Level of the register written |
| wr_dspace_i | input | 1 | Space of the register written |
| wr_page_i | input | 3 | Page of the register written |
| wr_sel_i | input | 1 | 0 = base register, 1 = descriptor |
| wr_data_i | input | 16 | Write data |
| pa_o | output | 22 | Physical address |
| desc_o | output | 16 | Descriptor of the selected page |

## Verification
Bases are loaded with a different value in every bank at the same page. Reading that page under each level and space then separates a wrong bank decode or a swapped data enable from a correct one. Bases near 0xFFFF and 0x0FFF, combined with block number 0x7F, exercise the carry wrap in both widths. A base with nonzero upper bits, read in 18-bit mode, shows whether those bits leak into the result. A sweep of translations with generated addresses across pages, levels and widths, followed by the bypass, reserved-level and reset cases, shows whether the block and offset fields are split at the right bit positions.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int unsigned VA_W     = 16;
  localparam int unsigned PA_W     = 22;
  localparam int unsigned PAGE_W   = 3;
  localparam int unsigned OFF_W    = 6;
  localparam int unsigned BLK_W    = VA_W - PAGE_W - OFF_W;
  localparam int unsigned BASE_W   = PA_W - OFF_W;
  localparam int unsigned NARROW_W = 12;
  localparam int unsigned DESC_W   = 16;
  localparam int unsigned N_LVL    = 3;
  localparam int unsigned N_SPACE  = 2;
  localparam int unsigned N_PAGES  = 1 << PAGE_W;
  localparam int unsigned N_BANKS  = N_LVL * N_SPACE;
  localparam int unsigned BANK_W   = $clog2(N_BANKS);
  localparam int unsigned ENT_W    = BANK_W + PAGE_W;

  typedef enum logic [1:0] {
    LVL_KERN = 2'b00,
    LVL_SUPV = 2'b01,
    LVL_RSVD = 2'b10,
    LVL_USER = 2'b11
  } lvl_e;
endpackage

// File: rtl/vx_bank_sel.sv
module vx_bank_sel
  import vx_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic             dspace_i,
  input  logic [N_LVL-1:0] dspace_en_i,
  output logic [BANK_W-1:0] bank_o,
  output logic             valid_o
);
  logic [1:0] lvl_idx;
  logic       use_d;

  always_comb begin
    valid_o = 1'b1;
    unique case (lvl_e'(mode_i))
      LVL_KERN: lvl_idx = 2'd0;
      LVL_SUPV: lvl_idx = 2'd1;
      LVL_USER: lvl_idx = 2'd2;
      default: begin
        lvl_idx = 2'd0;
        valid_o = 1'b0;
      end
    endcase
    use_d  = dspace_i & dspace_en_i[lvl_idx];
    bank_o = BANK_W'({lvl_idx, 1'b0}) | BANK_W'(use_d);
  end
endmodule

// File: rtl/vx_page_regs.sv
module vx_page_regs
  import vx_pkg::*;
#(
  parameter int unsigned N_ENT = N_BANKS * N_PAGES,
  parameter int unsigned IDX_W = ENT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DESC_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [DESC_W-1:0] rd_desc_o
);
  logic [BASE_W-1:0] base_q [N_ENT];
  logic [DESC_W-1:0] desc_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[e] <= '0;
        desc_q[e] <= '0;
      end else if (hit) begin
        if (wr_sel_i) desc_q[e] <= wr_data_i;
        else          base_q[e] <= BASE_W'(wr_data_i);
      end
    end
  end

  always_comb begin
    rd_base_o = '0;
    rd_desc_o = '0;
    if (32'(rd_idx_i) < N_ENT) begin
      rd_base_o = base_q[rd_idx_i];
      rd_desc_o = desc_q[rd_idx_i];
    end
  end
endmodule

// File: rtl/vx_reloc.sv
module vx_reloc
  import vx_pkg::*;
(
  input  logic [VA_W-1:0]   va_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              en_i,
  input  logic              valid_i,
  input  logic              map22_i,
  output logic [PA_W-1:0]   pa_o
);
  localparam int unsigned HI_W = BASE_W - NARROW_W;

  logic [BLK_W-1:0]    blk;
  logic [OFF_W-1:0]    off;
  logic [BASE_W-1:0]   base_eff;
  logic [BASE_W-1:0]   blk_sum;

  assign blk      = va_i[OFF_W +: BLK_W];
  assign off      = va_i[OFF_W-1:0];
  assign base_eff = map22_i ? base_i : {{HI_W{1'b0}}, base_i[NARROW_W-1:0]};
  assign blk_sum  = base_eff + BASE_W'(blk);

  always_comb begin
    if (!en_i)        pa_o = PA_W'(va_i);
    else if (!valid_i) pa_o = '0;
    else if (map22_i) pa_o = {blk_sum, off};
    else              pa_o = {{HI_W{1'b0}}, blk_sum[NARROW_W-1:0], off};
  end
endmodule

// File: rtl/vaddr_xlat.sv
module vaddr_xlat
  import vx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        mode_i,
  input  logic              dspace_i,
  input  logic              xlat_en_i,
  input  logic              map22_i,
  input  logic [N_LVL-1:0]  dspace_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_mode_i,
  input  logic              wr_dspace_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic              wr_sel_i,
  input  logic [DESC_W-1:0] wr_data_i,
  output logic [PA_W-1:0]   pa_o,
  output logic [DESC_W-1:0] desc_o
);
  logic [BANK_W-1:0] rd_bank, wr_bank;
  logic              rd_valid, wr_valid;
  logic [BASE_W-1:0] sel_base;
  logic [DESC_W-1:0] sel_desc;

  vx_bank_sel u_rd_sel (
    .mode_i     (mode_i),
    .dspace_i   (dspace_i),
    .dspace_en_i(dspace_en_i),
    .bank_o     (rd_bank),
    .valid_o    (rd_valid)
  );

  // write side always addresses the bank named, regardless of enables
  vx_bank_sel u_wr_sel (
    .mode_i     (wr_mode_i),
    .dspace_i   (wr_dspace_i),
    .dspace_en_i({N_LVL{1'b1}}),
    .bank_o     (wr_bank),
    .valid_o    (wr_valid)
  );

  vx_page_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i && wr_valid),
    .wr_sel_i (wr_sel_i),
    .wr_idx_i ({wr_bank, wr_page_i}),
    .wr_data_i(wr_data_i),
    .rd_idx_i ({rd_bank, va_i[VA_W-1 -: PAGE_W]}),
    .rd_base_o(sel_base),
    .rd_desc_o(sel_desc)
  );

  vx_reloc u_reloc (
    .va_i   (va_i),
    .base_i (sel_base),
    .en_i   (xlat_en_i),
    .valid_i(rd_valid),
    .map22_i(map22_i),
    .pa_o   (pa_o)
  );

  assign desc_o = (xlat_en_i && rd_valid) ? sel_desc : '0;
endmodule

// File: rtl/vaddr_xlat_checker.sv
module vaddr_xlat_checker
  import vx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VA_W-1:0]   va_i,
  input logic [1:0]        mode_i,
  input logic              dspace_i,
  input logic              xlat_en_i,
  input logic              map22_i,
  input logic [N_LVL-1:0]  dspace_en_i,
  input logic              wr_en_i,
  input logic [PA_W-1:0]   pa_o,
  input logic [DESC_W-1:0] desc_o
);
  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (pa_o == PA_W'(va_i) && desc_o == '0));

  assert_offset_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_en_i && mode_i != 2'b10) |-> pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]);

  assert_narrow_top_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_en_i && !map22_i) |-> pa_o[PA_W-1:18] == '0);

  assert_rsvd_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_en_i && mode_i == 2'b10) |-> (pa_o == '0 && desc_o == '0));

  assert_hold_without_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!wr_en_i) && $stable(va_i) && $stable(mode_i) && $stable(dspace_i) &&
     $stable(xlat_en_i) && $stable(map22_i) && $stable(dspace_en_i))
    |-> ($stable(pa_o) && $stable(desc_o)));
endmodule

bind vaddr_xlat vaddr_xlat_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .va_i       (va_i),
  .mode_i     (mode_i),
  .dspace_i   (dspace_i),
  .xlat_en_i  (xlat_en_i),
  .map22_i    (map22_i),
  .dspace_en_i(dspace_en_i),
  .wr_en_i    (wr_en_i),
  .pa_o       (pa_o),
  .desc_o     (desc_o)
);

// File: tb/vaddr_xlat_bench.sv
`timescale 1ns/1ps
module vaddr_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  mode = '0;
  logic        dsp = 1'b0, en = 1'b0, m22 = 1'b1;
  logic [2:0]  dse = '0;
  logic        wr_en = 1'b0, wr_dsp = 1'b0, wr_sel = 1'b0;
  logic [1:0]  wr_mode = '0;
  logic [2:0]  wr_page = '0;
  logic [15:0] wr_data = '0;
  logic [21:0] pa;
  logic [15:0] desc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] base_m [6][8];
  logic [15:0] desc_m [6][8];
  logic [21:0] exp_pa_q [$];
  logic [15:0] exp_desc_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  vaddr_xlat u_vaddr_xlat (
    .clk_i(clk), .rst_ni(rst_ni), .va_i(va), .mode_i(mode), .dspace_i(dsp),
    .xlat_en_i(en), .map22_i(m22), .dspace_en_i(dse), .wr_en_i(wr_en),
    .wr_mode_i(wr_mode), .wr_dspace_i(wr_dsp), .wr_page_i(wr_page),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .pa_o(pa), .desc_o(desc)
  );

  function automatic int lvl_of(logic [1:0] m);
    return (m == 2'b00) ? 0 : (m == 2'b01) ? 1 : (m == 2'b11) ? 2 : -1;
  endfunction

  task automatic clear_model();
    for (int b = 0; b < 6; b++)
      for (int p = 0; p < 8; p++) begin
        base_m[b][p] = '0;
        desc_m[b][p] = '0;
      end
  endtask

  // driver: write a register and mirror it in the model (R8, R10)
  task automatic wr_reg(logic [1:0] m, logic d, logic [2:0] pg, logic s, logic [15:0] v);
    int l;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_mode = m; wr_dsp = d; wr_page = pg; wr_sel = s; wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
    l = lvl_of(m);
    if (l >= 0) begin
      if (s) desc_m[l*2 + int'(d)][pg] = v;
      else   base_m[l*2 + int'(d)][pg] = v;
    end
  endtask

  // driver: apply a translation and push expected outputs
  task automatic xlat(string tag, logic [15:0] v, logic [1:0] m, logic d,
                      logic e, logic w22, logic [2:0] de);
    logic [21:0] ep;
    logic [15:0] ed, bs, sum16;
    logic [11:0] sum12;
    int l, b;
    @(posedge clk); #1;
    va = v; mode = m; dsp = d; en = e; m22 = w22; dse = de;
    l = lvl_of(m);
    if (!e) begin
      ep = {6'b0, v}; ed = '0;
    end else if (l < 0) begin
      ep = '0; ed = '0;
    end else begin
      b  = l*2 + int'(d & de[l]);
      bs = base_m[b][v[15:13]];
      ed = desc_m[b][v[15:13]];
      sum16 = bs + {9'b0, v[12:6]};
      sum12 = bs[11:0] + {5'b0, v[12:6]};
      ep = w22 ? {sum16, v[5:0]} : {4'b0, sum12, v[5:0]};
    end
    exp_pa_q.push_back(ep);
    exp_desc_q.push_back(ed);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_pa_q.size() > 0) begin
      logic [21:0] ep;
      logic [15:0] ed;
      string t;
      ep = exp_pa_q.pop_front();
      ed = exp_desc_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (pa !== ep || desc !== ed) begin
        errors++;
        $display("FAIL %s pa=%h desc=%h expected pa=%h desc=%h", t, pa, desc, ep, ed);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R9 reset state: all bases zero
    xlat("R9", 16'h2040, 2'b00, 1'b0, 1'b1, 1'b1, 3'b111);
    xlat("R9", 16'hFFFF, 2'b11, 1'b1, 1'b1, 1'b1, 3'b111);

    // R5 distinct base per bank at page 3
    for (int l = 0; l < 3; l++)
      for (int d = 0; d < 2; d++)
        wr_reg((l == 2) ? 2'b11 : 2'(l), 1'(d), 3'd3, 1'b0, 16'h0100 * 16'(l*2 + d + 1));
    for (int l = 0; l < 3; l++)
      for (int d = 0; d < 2; d++)
        xlat("R5", 16'h6000 | 16'h0abc, (l == 2) ? 2'b11 : 2'(l), 1'(d), 1'b1, 1'b1, 3'b111);

    // R7 data bank disabled per level: data refs use the instruction bank
    xlat("R7", 16'h6123, 2'b00, 1'b1, 1'b1, 1'b1, 3'b110);
    xlat("R7", 16'h6123, 2'b01, 1'b1, 1'b1, 1'b1, 3'b101);
    xlat("R7", 16'h6123, 2'b11, 1'b1, 1'b1, 1'b1, 3'b011);
    xlat("R7", 16'h6123, 2'b11, 1'b1, 1'b1, 1'b1, 3'b100);

    // R2 wrap in 22-bit mode: base FFF0 + block 7F
    wr_reg(2'b00, 1'b0, 3'd7, 1'b0, 16'hFFF0);
    xlat("R2", 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000);
    xlat("R2", 16'hE000, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000);
    // R4 18-bit: upper base bits dropped, wrap at 12 bits
    wr_reg(2'b00, 1'b0, 3'd5, 1'b0, 16'hAFFF);
    xlat("R4", 16'hBFC1, 2'b00, 1'b0, 1'b1, 1'b0, 3'b000);
    xlat("R4", 16'hFFFF, 2'b00, 1'b0, 1'b1, 1'b0, 3'b000);
    xlat("R2", 16'hBFC1, 2'b00, 1'b0, 1'b1, 1'b1, 3'b000);

    // R6 translation off
    xlat("R6", 16'hBEEF, 2'b00, 1'b0, 1'b0, 1'b1, 3'b111);
    xlat("R6", 16'hFFFF, 2'b11, 1'b1, 1'b0, 1'b0, 3'b111);

    // R11 descriptor shown; R8 descriptor write leaves base unchanged
    wr_reg(2'b01, 1'b1, 3'd2, 1'b1, 16'h7F06);
    xlat("R11", 16'h4000, 2'b01, 1'b1, 1'b1, 1'b1, 3'b111);
    xlat("R8", 16'h4000, 2'b01, 1'b0, 1'b1, 1'b1, 3'b111);

    // R10 reserved level: output zero, writes dropped
    wr_reg(2'b10, 1'b0, 3'd3, 1'b0, 16'h5555);
    wr_reg(2'b10, 1'b1, 3'd3, 1'b1, 16'h5555);
    xlat("R10", 16'h6abc, 2'b10, 1'b0, 1'b1, 1'b1, 3'b111);
    for (int l = 0; l < 3; l++)
      for (int d = 0; d < 2; d++)
        xlat("R10", 16'h6000, (l == 2) ? 2'b11 : 2'(l), 1'(d), 1'b1, 1'b1, 3'b111);

    // R1 R3 sweep: generated addresses across pages with distinct bases
    for (int p = 0; p < 8; p++) wr_reg(2'b11, 1'b0, 3'(p), 1'b0, 16'h1234 + 16'(p * 16'h0F11));
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xlat((i % 2) ? "R1" : "R3", lfsr, 2'b11, 1'b0, 1'b1, 1'(i % 3 != 0), 3'b000);
    end

    // R9 asynchronous reset mid-run
    @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    clear_model();
    @(posedge clk); #1;
    rst_ni = 1'b1;
    xlat("R9", 16'h6abc, 2'b00, 1'b0, 1'b1, 1'b1, 3'b111);
    xlat("R9", 16'h4000, 2'b01, 1'b1, 1'b1, 1'b1, 3'b111);

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule